// File: doc/BRIEF.md
# Nonvolatile Configuration Commit Sequencer

This block holds the live configuration bytes of a clock-generator style device. It also keeps a nonvolatile copy of them, modelled as an internal array that survives the block's reset. A serial slave reads and writes the live bytes through a simple byte port. Writing a 0-to-1 transition onto a trigger bit starts a commit. The commit copies every live byte into the stored array in ascending offset order, spending a fixed number of clock cycles on each byte.

After every reset the sequencer copies the stored array back into the live registers, one byte per cycle. The device therefore comes up in its saved configuration, or in the factory image. While a copy runs in either direction, a busy flag blocks incoming writes, and the same flag appears as a readable status bit.

Two controls act only from stored content. The first is a lock bit, which refuses further commits. The second is the mode bit that gives the shared pins to control use instead of serial use. A force input puts the pins back in serial mode and zeroes the two programmable address bits.

Top module: `nv_commit_seq`

## Requirements
- R1: While reset is held, busy reads 1. After reset is released, busy stays 1 for exactly NBYTES cycles while the stored image is copied into the live bytes. The factory image holds the value i in byte i.
- R2: When busy is 0, a write to an offset below NBYTES replaces that live byte. The read port returns live bytes combinationally. A read of an offset at or above NBYTES returns 0.
- R3: A commit starts one cycle after a 0-to-1 transition of the trigger bit, which is byte 06h bit 0. Busy then stays 1 for NBYTES*SLOT_CYCLES cycles.
- R4: A trigger bit that stays at 1 starts no further commit. It must be written to 0 and then to 1 again.
- R5: Byte 01h bit 6 reads as the busy flag.
- R6: Writes that arrive while busy is 1 are dropped.
- R7: A commit stores every live byte, in ascending offset order. The stored copy of the trigger bit is always 0. After the next reset the committed values are the live values.
- R8: Once the lock bit (byte 01h bit 5) is 1 in the stored image, no commit starts. Live writes still take effect.
- R9: A lock bit that is set only in the live bytes does not prevent a commit.
- R10: The pinsAsControl output follows the stored byte 02h bit 6 and never the live copy of that bit.
- R11: While forceSerial is 1, pinsAsControl is 0, and live byte 01h bits [1:0] are cleared. addrLsb reports those two bits, and they stay 0 after forceSerial is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-up reset; starts the restore |
| regWrEn | input | 1 | Live byte write strobe from the serial slave |
| regWrAddr | input | ADDR_W | Write offset |
| regWrData | input | 8 | Write data |
| regRdAddr | input | ADDR_W | Read offset |
| regRdData | output | 8 | Live byte at regRdAddr, with busy overlaid on byte 01h bit 6 |
| forceSerial | input | 1 | Forces serial pin mode and clears the address bits |
| busy | output | 1 | Restore or commit in progress; writes are dropped |
| pinsAsControl | output | 1 | 1 when the stored image gives the shared pins to control use |
| addrLsb | output | 2 | Programmable low address bits from live byte 01h |

## Verification
A slot counter or byte index in the wrong state shows as a busy window that differs from NBYTES*SLOT_CYCLES cycles. The bench measures that window, so the error is reported within one commit. A faulty edge detector or lock decode shows as a busy pulse where none is allowed, or a missing pulse where one is required, within two cycles of the trigger write. Stored-image corruption stays hidden until the next reset. It then appears as wrong readback values right after the NBYTES-cycle restore.

// File: rtl/nvc_pkg.sv
package nvc_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic restoreWr;  // copy stored byte idx into the live image
    logic commitWr;   // copy live byte idx into the stored image
  } nvStrobe_t;

  typedef enum logic [1:0] {
    ST_RESTORE = 2'd0,
    ST_IDLE    = 2'd1,
    ST_COMMIT  = 2'd2
  } nvState_t;

  // Bit positions that other logic decodes
  localparam int TRIG_BYTE = 6;
  localparam int TRIG_BIT  = 0;
  localparam int STAT_BYTE = 1;
  localparam int BUSY_BIT  = 6;
  localparam int LOCK_BIT  = 5;
  localparam int PIN_BYTE  = 2;
  localparam int PIN_BIT   = 6;

endpackage

// File: rtl/nvc_ctrl.sv
module nvc_ctrl
  import nvc_pkg::*;
#(
  parameter int NBYTES      = 16,
  parameter int SLOT_CYCLES = 5,
  localparam int IDX_W  = $clog2(NBYTES),
  localparam int SLOT_W = $clog2(SLOT_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trigEdge,
  input  logic             nvLocked,
  output nvStrobe_t        stb,
  output logic [IDX_W-1:0] idx,
  output logic             busy
);

  localparam logic [IDX_W-1:0]  LAST_IDX  = IDX_W'(NBYTES - 1);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOT_CYCLES - 1);

  nvState_t          state;
  logic [SLOT_W-1:0] slotCnt;
  logic              slotDone;

  assign slotDone = (slotCnt == LAST_SLOT);

  always_comb begin
    stb           = '0;
    stb.restoreWr = (state == ST_RESTORE);
    stb.commitWr  = (state == ST_COMMIT) && slotDone;
  end

  assign busy = (state != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_RESTORE;
      idx     <= '0;
      slotCnt <= '0;
    end else begin
      unique case (state)
        ST_RESTORE: begin
          if (idx == LAST_IDX) begin
            state <= ST_IDLE;
            idx   <= '0;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        ST_IDLE: begin
          if (trigEdge && !nvLocked) begin
            state   <= ST_COMMIT;
            idx     <= '0;
            slotCnt <= '0;
          end
        end
        ST_COMMIT: begin
          if (slotDone) begin
            slotCnt <= '0;
            if (idx == LAST_IDX) begin
              state <= ST_IDLE;
              idx   <= '0;
            end else begin
              idx <= idx + 1'b1;
            end
          end else begin
            slotCnt <= slotCnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R8
  locked_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && nvLocked) |=> state == ST_IDLE);

  // R3
  edge_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && trigEdge && !nvLocked) |=>
      (state == ST_COMMIT && idx == '0 && slotCnt == '0));

  // R7
  commit_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_COMMIT && $past(state) == ST_COMMIT) |-> idx >= $past(idx));

endmodule

// File: rtl/nvc_datapath.sv
module nvc_datapath
  import nvc_pkg::*;
#(
  parameter int NBYTES = 16,
  parameter int ADDR_W = 5,
  localparam int IDX_W = $clog2(NBYTES),
  localparam int IMG_W = NBYTES * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  nvStrobe_t         stb,
  input  logic [IDX_W-1:0]  idx,
  input  logic              busy,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regWrAddr,
  input  logic [7:0]        regWrData,
  input  logic [ADDR_W-1:0] regRdAddr,
  output logic [7:0]        regRdData,
  input  logic              forceSerial,
  output logic              trigEdge,
  output logic              nvLocked,
  output logic              pinsAsControl,
  output logic [1:0]        addrLsb
);

  function automatic logic [IMG_W-1:0] factoryImage();
    logic [IMG_W-1:0] r;
    for (int i = 0; i < NBYTES; i++) r[i*8 +: 8] = 8'(i);
    return r;
  endfunction

  localparam logic [IMG_W-1:0] FACTORY = factoryImage();

  logic [IMG_W-1:0] liveImg;
  logic [IMG_W-1:0] nvMem = FACTORY;  // survives reset
  logic             trigPrev;
  logic             wrOk;
  logic [7:0]       commitByte;

  assign wrOk = regWrEn && !busy && (regWrAddr < ADDR_W'(NBYTES));

  always_comb begin
    commitByte = liveImg[idx*8 +: 8];
    if (idx == IDX_W'(TRIG_BYTE)) commitByte[TRIG_BIT] = 1'b0;
  end

  // live register image
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      liveImg <= '0;
    end else begin
      if (stb.restoreWr) liveImg[idx*8 +: 8] <= nvMem[idx*8 +: 8];
      else if (wrOk)     liveImg[regWrAddr[IDX_W-1:0]*8 +: 8] <= regWrData;
      if (forceSerial)   liveImg[STAT_BYTE*8 +: 2] <= 2'b00;
    end
  end

  // stored image: no reset, content persists
  always_ff @(posedge clk) begin
    if (stb.commitWr) nvMem[idx*8 +: 8] <= commitByte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trigPrev <= 1'b0;
    else        trigPrev <= liveImg[TRIG_BYTE*8 + TRIG_BIT];
  end

  assign trigEdge      = liveImg[TRIG_BYTE*8 + TRIG_BIT] && !trigPrev;
  assign nvLocked      = nvMem[STAT_BYTE*8 + LOCK_BIT];
  assign pinsAsControl = nvMem[PIN_BYTE*8 + PIN_BIT] && !forceSerial;
  assign addrLsb       = forceSerial ? 2'b00 : liveImg[STAT_BYTE*8 +: 2];

  always_comb begin
    regRdData = 8'h00;
    if (regRdAddr < ADDR_W'(NBYTES)) begin
      regRdData = liveImg[regRdAddr[IDX_W-1:0]*8 +: 8];
      if (regRdAddr == ADDR_W'(STAT_BYTE)) regRdData[BUSY_BIT] = busy;
    end
  end

  // R6
  blocked_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (regWrEn && busy && !forceSerial && !stb.restoreWr) |=> $stable(liveImg));

  // R7
  stored_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.commitWr && idx == IDX_W'(TRIG_BYTE)) |=> !nvMem[TRIG_BYTE*8 + TRIG_BIT]);

  // R11
  ovr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    forceSerial |=> liveImg[STAT_BYTE*8 +: 2] == 2'b00);

  // R1
  restore_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb.restoreWr |-> busy);

endmodule

// File: rtl/nv_commit_seq.sv
module nv_commit_seq
  import nvc_pkg::*;
#(
  parameter int NBYTES      = 16,
  parameter int SLOT_CYCLES = 5,
  parameter int ADDR_W      = $clog2(NBYTES) + 1,
  localparam int IDX_W = $clog2(NBYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regWrAddr,
  input  logic [7:0]        regWrData,
  input  logic [ADDR_W-1:0] regRdAddr,
  output logic [7:0]        regRdData,
  input  logic              forceSerial,
  output logic              busy,
  output logic              pinsAsControl,
  output logic [1:0]        addrLsb
);

  nvStrobe_t        stb;
  logic [IDX_W-1:0] idx;
  logic             trigEdge;
  logic             nvLocked;

  nvc_ctrl #(.NBYTES(NBYTES), .SLOT_CYCLES(SLOT_CYCLES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .trigEdge(trigEdge), .nvLocked(nvLocked),
    .stb(stb), .idx(idx), .busy(busy)
  );

  nvc_datapath #(.NBYTES(NBYTES), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .stb(stb), .idx(idx), .busy(busy),
    .regWrEn(regWrEn), .regWrAddr(regWrAddr), .regWrData(regWrData),
    .regRdAddr(regRdAddr), .regRdData(regRdData), .forceSerial(forceSerial),
    .trigEdge(trigEdge), .nvLocked(nvLocked), .pinsAsControl(pinsAsControl),
    .addrLsb(addrLsb)
  );

endmodule

// File: tb/sim_nv_commit_seq.sv
module sim_nv_commit_seq;

  localparam int NB     = 16;
  localparam int SLOT   = 5;
  localparam int AW     = 5;
  localparam int COMMIT = NB * SLOT;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          regWrEn = 1'b0;
  logic [AW-1:0] regWrAddr = '0;
  logic [7:0]    regWrData = '0;
  logic [AW-1:0] regRdAddr = '0;
  logic [7:0]    regRdData;
  logic          forceSerial = 1'b0;
  logic          busy;
  logic          pinsAsControl;
  logic [1:0]    addrLsb;

  int nChk = 0;
  int nFail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  nv_commit_seq #(.NBYTES(NB), .SLOT_CYCLES(SLOT), .ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .regWrEn(regWrEn), .regWrAddr(regWrAddr),
    .regWrData(regWrData), .regRdAddr(regRdAddr), .regRdData(regRdData),
    .forceSerial(forceSerial), .busy(busy), .pinsAsControl(pinsAsControl),
    .addrLsb(addrLsb)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wrByte(input int a, input int d);
    @(negedge clk);
    regWrEn = 1'b1; regWrAddr = AW'(a); regWrData = 8'(d);
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdByte(input int a, output int d);
    regRdAddr = AW'(a);
    #1 d = int'(regRdData);
  endtask

  // pulse reset and count restore busy cycles
  task automatic powerCycle(output int n);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    #1 check(busy == 1'b1, "R1 busy in reset", int'(busy), 1);
    @(negedge clk);
    rst_n = 1'b1;
    n = 0;
    for (int k = 0; k < 30; k++) begin
      #1 if (busy) n++;
      @(negedge clk);
    end
  endtask

  // write trigger 0 then 1, count busy cycles; probe writes and status
  task automatic commitWindow(input bit probe, output int n);
    wrByte(6, 0);
    wrByte(6, 1);
    n = 0;
    for (int k = 0; k < COMMIT + 20; k++) begin
      @(negedge clk);
      regWrEn = 1'b0;
      if (probe && k == 1) begin
        regWrEn = 1'b1; regWrAddr = AW'(3); regWrData = 8'hAA;
        regRdAddr = AW'(1);
        #1 check(regRdData[6] == 1'b1, "R5 status during commit", int'(regRdData[6]), 1);
      end
      #1 if (busy) n++;
    end
    regWrEn = 1'b0;
  endtask

  task automatic tReset();
    int n, d;
    powerCycle(n);
    check(n == NB, "R1 restore busy length", n, NB);
    for (int i = 0; i < NB; i++) begin
      rdByte(i, d);
      check(d == i, "R1 factory byte", d, i);
    end
    #1 check(pinsAsControl == 1'b0, "R10 default serial mode", int'(pinsAsControl), 0);
    check(addrLsb == 2'b01, "R11 addrLsb from byte 01h", int'(addrLsb), 1);
  endtask

  task automatic tLiveRw();
    int d;
    wrByte(3, 8'h5A);
    rdByte(3, d);
    check(d == 8'h5A, "R2 live write readback", d, 8'h5A);
    rdByte(20, d);
    check(d == 0, "R2 out of range read", d, 0);
    rdByte(1, d);
    check(d[6] == 1'b0, "R5 status idle", d[6], 0);
  endtask

  task automatic tCommit();
    int n, d;
    wrByte(9, 8'hC3);
    wrByte(2, 8'h42);
    #1 check(pinsAsControl == 1'b0, "R10 live pin bit ignored", int'(pinsAsControl), 0);
    commitWindow(1'b1, n);
    check(n == COMMIT, "R3 commit busy length", n, COMMIT);
    rdByte(3, d);
    check(d == 8'h5A, "R6 write during busy dropped", d, 8'h5A);
    rdByte(1, d);
    check(d[6] == 1'b0, "R5 status after commit", d[6], 0);
    #1 check(pinsAsControl == 1'b1, "R10 stored pin bit", int'(pinsAsControl), 1);
  endtask

  task automatic tHeld();
    int n = 0;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      #1 if (busy) n++;
    end
    check(n == 0, "R4 held trigger no restart", n, 0);
    commitWindow(1'b0, n);
    check(n == COMMIT, "R4 retrigger after clear", n, COMMIT);
  endtask

  task automatic tRestore();
    int n, d;
    powerCycle(n);
    check(n == NB, "R7 restore busy length", n, NB);
    rdByte(9, d);
    check(d == 8'hC3, "R7 committed byte 09h", d, 8'hC3);
    rdByte(3, d);
    check(d == 8'h5A, "R7 committed byte 03h", d, 8'h5A);
    rdByte(6, d);
    check(d == 0, "R7 stored trigger bit zero", d, 0);
    rdByte(2, d);
    check(d == 8'h42, "R7 committed byte 02h", d, 8'h42);
  endtask

  task automatic tOverride();
    int d;
    wrByte(1, 8'h03);
    #1 check(addrLsb == 2'b11, "R11 addrLsb written", int'(addrLsb), 3);
    @(negedge clk);
    forceSerial = 1'b1;
    #1 check(pinsAsControl == 1'b0, "R11 forced serial", int'(pinsAsControl), 0);
    check(addrLsb == 2'b00, "R11 addrLsb forced", int'(addrLsb), 0);
    @(negedge clk);
    @(negedge clk);
    forceSerial = 1'b0;
    rdByte(1, d);
    check(d[1:0] == 2'b00, "R11 address bits cleared", d[1:0], 0);
    #1 check(pinsAsControl == 1'b1, "R11 release restores mode", int'(pinsAsControl), 1);
  endtask

  task automatic tLock();
    int n, d;
    wrByte(1, 8'h20);
    commitWindow(1'b0, n);
    check(n == COMMIT, "R9 live lock does not block", n, COMMIT);
    commitWindow(1'b0, n);
    check(n == 0, "R8 stored lock blocks commit", n, 0);
    wrByte(4, 8'h77);
    rdByte(4, d);
    check(d == 8'h77, "R8 live write after lock", d, 8'h77);
  endtask

  initial begin
    tReset();
    tLiveRw();
    tCommit();
    tHeld();
    tRestore();
    tOverride();
    tLock();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChk++;
      nFail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", nChk, nFail);
      $finish;
    end
  end

endmodule